// File: doc/BRIEF.md
# DMA Half-Transfer Completion Monitor

This block watches the remaining transfer count of one DMA channel. When software or the channel sequencer loads a start count, the block latches a half-way threshold: the start value shifted right by one bit, so an odd start rounds down. A start value of all zeros means the largest possible transfer, 2^CNT_W transfers, and its threshold is 2^(CNT_W-1). Each transfer strobe lowers the count by one. The decrement that brings the count down to the threshold raises a sticky half-done flag, but only while the half-done interrupt enable is set.

Any of four abort events stops the count. These are a non-maskable interrupt, an address error, the channel enable being cleared and the master enable being cleared. After an abort the block ignores further transfer strobes until a new start count arrives. A flag that is already set survives the abort. A two-bit register port gives access to the flag and the enable. The flag can only be cleared by writing 0 to it after a read has returned it as 1. The interrupt request follows the flag gated by the enable.

Top module: `dma_half_mon`

## Requirements
- R1: A load strobe sets the remaining count to the loaded value. An all-zero value sets it to 2^CNT_W, and the count is visible on `remain_o`.
- R2: The threshold latched at load is floor(value/2), or 2^(CNT_W-1) for an all-zero value. It stays fixed until the next load. The flag (`reg_rdata_o` bit 0) reads 1 in the cycle after the decrement that makes the count equal the threshold.
- R3: Each accepted transfer strobe lowers the count by exactly one. A strobe with the count at 0 leaves it at 0.
- R4: The flag sets only if the enable (`reg_rdata_o` bit 1) is 1 when the threshold is reached. A threshold reached with the enable at 0 leaves the flag at 0, and setting the enable later does not raise it.
- R5: Any one of the four abort inputs stops the count. Later transfer strobes leave the count unchanged and cannot set the flag until the next load. After reset the block is stopped the same way.
- R6: A set flag stays set through any abort event.
- R7: A write with data bit 0 = 0 clears the flag only if a read that returned flag = 1 came earlier. A write with bit 0 = 1 never changes the flag, and a write of 0 without that earlier read leaves it set. Every write loads the enable from data bit 1.
- R8: Every write uses up the read arming, so each clear needs a fresh read that returns 1.
- R9: If a flag-setting decrement and an armed clearing write fall in the same cycle, the flag ends up set.
- R10: `irq_o` is 1 exactly when the flag and the enable are both 1.
- R11: Reset leaves flag, enable, `irq_o` and `remain_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Start-count load strobe |
| load_val_i | input | CNT_W | Start count (0 means 2^CNT_W) |
| dec_i | input | 1 | One-transfer-done strobe |
| abort_nmi_i | input | 1 | Non-maskable interrupt abort |
| abort_aerr_i | input | 1 | Address error abort |
| abort_chen_i | input | 1 | Channel enable cleared |
| abort_mren_i | input | 1 | Master enable cleared |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 2 | Write data: bit 1 enable, bit 0 flag |
| reg_rdata_o | output | 2 | Read data: bit 1 enable, bit 0 flag |
| irq_o | output | 1 | Half-done interrupt request |
| remain_o | output | CNT_W+1 | Remaining transfer count |

## Verification
The bench builds the monitor with CNT_W = 8 rather than the default 24. At that width the all-zero start value means 256 transfers with a threshold of 128, so the maximum-count rule can be walked to the threshold and one step short of it in a few hundred cycles. The narrow width also reaches the smallest start values, where the threshold is 0 and the count saturates at zero. Directed cases cover each abort source, arming being used up by a write, and a set racing a clear in the same cycle.

// File: rtl/dma_half_pkg.sv
package dma_half_pkg;

    localparam int FLAG_BIT = 0;
    localparam int IE_BIT   = 1;

    typedef struct packed {
        logic flag;
        logic ie;
        logic armed;
    } hf_state_t;

endpackage

// File: rtl/dhm_count.sv
module dhm_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    input  logic             abort_i,
    output logic [CNT_W:0]   cnt_o,
    output logic             hit_o
);
    localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] HALF = FULL >> 1;
    localparam logic [CNT_W:0] ONE  = {{CNT_W{1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W:0] cnt;
        logic [CNT_W:0] thr;
        logic           active;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       take;

    always_comb begin
        s_d   = s_q;
        hit_o = 1'b0;
        take  = dec_i && s_q.active && (s_q.cnt != '0);
        if (abort_i) begin
            s_d.active = 1'b0;
        end else if (load_i) begin
            s_d.active = 1'b1;
            if (load_val_i == '0) begin
                s_d.cnt = FULL;
                s_d.thr = HALF;
            end else begin
                s_d.cnt = {1'b0, load_val_i};
                s_d.thr = {1'b0, load_val_i} >> 1;
            end
        end else if (take) begin
            s_d.cnt = s_q.cnt - ONE;
            hit_o   = ((s_q.cnt - ONE) == s_q.thr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.active && !load_i) |=> $stable(s_q.cnt));

    // R2
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(s_q.thr));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && s_q.active && s_q.cnt != '0 && !load_i && !abort_i)
        |=> (s_q.cnt == $past(s_q.cnt) - ONE));

    // R3
    no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (s_q.cnt <= $past(s_q.cnt)));

endmodule

// File: rtl/dhm_flag.sv
module dhm_flag
    import dma_half_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  logic       rd_i,
    input  logic       wr_i,
    input  logic [1:0] wdata_i,
    output logic       flag_o,
    output logic       ie_o,
    output logic       irq_o
);
    hf_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.ie    = wdata_i[IE_BIT];
            s_d.armed = 1'b0;
            if (s_q.armed && !wdata_i[FLAG_BIT]) begin
                s_d.flag = 1'b0;
            end
        end else if (rd_i && s_q.flag) begin
            s_d.armed = 1'b1;
        end
        if (hit_i && s_q.ie) begin
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_o = s_q.flag;
    assign ie_o   = s_q.ie;
    assign irq_o  = s_q.flag & s_q.ie;

    // R4
    set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> ($past(hit_i) && $past(s_q.ie)));

    // R7
    clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.flag) |-> ($past(wr_i) && $past(s_q.armed)));

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !wr_i) |=> s_q.flag);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && s_q.ie) |=> s_q.flag);

endmodule

// File: rtl/dma_half_mon.sv
module dma_half_mon #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    input  logic             abort_nmi_i,
    input  logic             abort_aerr_i,
    input  logic             abort_chen_i,
    input  logic             abort_mren_i,
    input  logic             reg_rd_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_wdata_i,
    output logic [1:0]       reg_rdata_o,
    output logic             irq_o,
    output logic [CNT_W:0]   remain_o
);
    import dma_half_pkg::*;

    logic abort_any;
    logic hit;
    logic flag;
    logic ie;

    assign abort_any = abort_nmi_i | abort_aerr_i | abort_chen_i | abort_mren_i;

    dhm_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .dec_i      (dec_i),
        .abort_i    (abort_any),
        .cnt_o      (remain_o),
        .hit_o      (hit)
    );

    dhm_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .rd_i    (reg_rd_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .flag_o  (flag),
        .ie_o    (ie),
        .irq_o   (irq_o)
    );

    always_comb begin
        reg_rdata_o           = '0;
        reg_rdata_o[FLAG_BIT] = flag;
        reg_rdata_o[IE_BIT]   = ie;
    end

endmodule

// File: tb/dma_half_mon_test.sv
`timescale 1ns/1ps
module dma_half_mon_test;
    localparam int W  = 8;
    localparam int NV = 10;
    // {start value, decrement count, enable, expected flag}
    localparam logic [18:0] VEC [NV] = '{
        {8'd10, 9'd4,   1'b1, 1'b0},
        {8'd10, 9'd5,   1'b1, 1'b1},
        {8'd11, 9'd6,   1'b1, 1'b1},
        {8'd11, 9'd5,   1'b1, 1'b0},
        {8'd1,  9'd1,   1'b1, 1'b1},
        {8'd0,  9'd128, 1'b1, 1'b1},
        {8'd0,  9'd127, 1'b1, 1'b0},
        {8'd10, 9'd5,   1'b0, 1'b0},
        {8'd3,  9'd5,   1'b1, 1'b1},
        {8'd255,9'd128, 1'b1, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic load = 1'b0, dec = 1'b0;
    logic nmi = 1'b0, aerr = 1'b0, chen = 1'b0, mren = 1'b0;
    logic rd = 1'b0, wr = 1'b0;
    logic [W-1:0] lval = '0;
    logic [1:0] wdata = '0;
    logic [1:0] rdata;
    logic irq;
    logic [W:0] remain;
    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    dma_half_mon #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(lval), .dec_i(dec),
        .abort_nmi_i(nmi), .abort_aerr_i(aerr), .abort_chen_i(chen), .abort_mren_i(mren),
        .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .remain_o(remain)
    );

    task automatic cyc(); @(negedge clk); endtask

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(logic [W-1:0] v);
        load = 1'b1; lval = v; cyc(); load = 1'b0;
    endtask

    task automatic do_dec(int n);
        if (n > 0) begin dec = 1'b1; repeat (n) cyc(); dec = 1'b0; end
    endtask

    task automatic reg_write(logic [1:0] d);
        wr = 1'b1; wdata = d; cyc(); wr = 1'b0;
    endtask

    task automatic reg_read(output logic [1:0] r);
        rd = 1'b1; r = rdata; cyc(); rd = 1'b0;
    endtask

    task automatic pulse_abort(logic [3:0] m);
        {mren, chen, aerr, nmi} = m; cyc(); {mren, chen, aerr, nmi} = 4'b0;
    endtask

    task automatic clear_flag(logic en);
        logic [1:0] r;
        reg_read(r);
        reg_write({en, 1'b0});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] r;
        int st, ec;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R11 reset state
        chk("R11 rdata", rdata, 0);
        chk("R11 irq", irq, 0);
        chk("R11 remain", remain, 0);
        // R5 stopped after reset: strobes ignored
        do_dec(3);
        chk("R5 remain after reset", remain, 0);

        // table walk: R1 R2 R3 R4 R10
        for (int i = 0; i < NV; i++) begin
            clear_flag(VEC[i][1]);
            do_load(VEC[i][18:11]);
            st = (VEC[i][18:11] == 0) ? (1 << W) : int'(VEC[i][18:11]);
            chk("R1 loaded count", remain, st);
            do_dec(int'(VEC[i][10:2]));
            ec = (st > int'(VEC[i][10:2])) ? st - int'(VEC[i][10:2]) : 0;
            chk("R3 count", remain, ec);
            chk("R2 flag", rdata[0], VEC[i][0]);
            chk("R10 irq", irq, VEC[i][0] & VEC[i][1]);
        end

        // R5 each abort source
        for (int k = 0; k < 4; k++) begin
            clear_flag(1'b1);
            do_load(8'd10);
            do_dec(2);
            pulse_abort(4'(1 << k));
            do_dec(6);
            chk("R5 count frozen", remain, 8);
            chk("R5 flag not set", rdata[0], 0);
        end

        // R6 sticky through abort
        clear_flag(1'b1);
        do_load(8'd10);
        do_dec(5);
        chk("R6 flag set", rdata[0], 1);
        pulse_abort(4'b0001);
        pulse_abort(4'b0100);
        chk("R6 flag kept", rdata[0], 1);
        chk("R6 irq kept", irq, 1);

        // R7 clear rules
        reg_write(2'b11);
        chk("R7 write 1 no effect", rdata[0], 1);
        reg_write(2'b10);
        chk("R7 unarmed write 0", rdata[0], 1);
        reg_read(r);
        chk("R7 read returns 1", r[0], 1);
        reg_write(2'b10);
        chk("R7 armed clear", rdata[0], 0);
        chk("R7 irq dropped", irq, 0);

        // R8 arming used up by any write
        do_load(8'd10);
        do_dec(5);
        reg_read(r);
        reg_write(2'b11);
        reg_write(2'b10);
        chk("R8 arm consumed", rdata[0], 1);

        // R9 set beats clear in the same cycle
        reg_read(r);
        do_load(8'd4);
        do_dec(1);
        dec = 1'b1; wr = 1'b1; wdata = 2'b10;
        cyc();
        dec = 1'b0; wr = 1'b0;
        chk("R9 count", remain, 2);
        chk("R9 set wins", rdata[0], 1);
        reg_write(2'b10);
        chk("R8 arm consumed by race write", rdata[0], 1);
        clear_flag(1'b0);
        chk("R7 cleared", rdata, 0);

        // R4 threshold with enable off, enable later
        do_load(8'd6);
        do_dec(3);
        chk("R4 no set with enable 0", rdata[0], 0);
        reg_write(2'b10);
        do_dec(1);
        chk("R4 late enable", rdata[0], 0);
        chk("R4 irq", irq, 0);
        chk("R4 count", remain, 2);

        // R10 irq gated by enable
        do_load(8'd6);
        do_dec(3);
        chk("R10 irq on", irq, 1);
        reg_write(2'b00);
        chk("R10 rdata", rdata, 1);
        chk("R10 irq off", irq, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule